// File: doc/BRIEF.md
# Quad-Lane Byte/Word FIFO Pair with Latched Status

This block holds the data buffering of a serial flash/peripheral controller. Both the transmit and the receive direction have their own storage, built from four byte-wide lanes of `LANE_DEPTH` entries each. The bus side can move a 32-bit word, which pushes or pops one byte in every lane at once. It can also move a single byte, which always uses lane 0. The serial side moves one byte at a time. In word mode it walks the lanes in the order 0, 1, 2, 3 and back to 0. In byte mode it stays on lane 0. Lane 0 carries the least significant byte of a word. Software should change `word_mode` only while both directions are empty.

A latched status vector collects the fill flags of both directions and an illegal-access event. The illegal-access event is raised by a bus write into a full store or a bus read from an empty one. Each status bit stays set until a one is written to its position of the clear mask. A condition that is still true sets its bit again on the following cycle. A maskable interrupt output is the OR of the enabled status bits. Software can pace transfers by polling these bits, and a DMA engine can pace on the trigger levels.

Top module: `quad_lane_fifo`

## Requirements
- R1: A word write pushes bits [8l+7:8l] into lane l for every lane l in the same cycle. A word read pops every lane and returns lane l in bits [8l+7:8l] of `rx_rdata_w`. That output is registered and valid after the clock edge that accepted the read.
- R2: A byte write pushes only lane 0, and a byte read pops only lane 0 into the registered `rx_rdata_b`. With `word_mode`=0 the effective depth is `LANE_DEPTH` bytes. With `word_mode`=1 it is 4×`LANE_DEPTH` bytes.
- R3: With `word_mode`=1 the serial side serves lanes in the rotating order 0,1,2,3,0,... With `word_mode`=0 it uses lane 0 only. `tx_ser_valid` is low when the selected lane is empty, and a take is then ignored. `rx_ser_ready` is low when the selected lane is full, and a put is then dropped with no status effect.
- R4: Transmit status bits are 0 = trigger (fill level ≤ `TX_TRIG`), 1 = empty, 2 = half-full (level ≥ capacity/2) and 3 = full. In word mode the level is the byte total of all lanes, the capacity is 64 and full means any lane is full. In byte mode the level is the lane-0 count, the capacity is 16 and full means lane 0 is full.
- R5: Receive status bits are 5 = trigger (level ≥ `RX_TRIG`), 6 = a whole word available (every lane holds at least one byte), 7 = half-full, 8 = full and 11 = a byte available (lane 0 not empty). Level, capacity and full follow the same mode rules as R4. Bits 4, 9 and 10 are always 0.
- R6: A status bit is set on the clock edge after its condition holds and stays set while the condition goes false. A clear write with a one in a bit position zeroes that bit at that edge. If the condition is still true, the bit is set again at the next edge.
- R7: These accesses are refused: a word write while any transmit lane is full, a byte write while transmit lane 0 is full, a word read while any receive lane is empty, and a byte read while receive lane 0 is empty. A refused access moves no data and sets status bit 12 with the same timing as the other flags.
- R8: `irq` is high exactly when some status bit is set whose `ien` bit is also set. `ien` resets to 0x1000 (only bit 12) and is replaced whole by an enable write.
- R9: When a word access and a byte access of the same direction arrive in the same cycle, only the word access takes effect. The byte access is ignored.
- R10: During and right after reset the status is 0, `irq` is 0, `tx_ser_valid` is 0, `rx_ser_ready` is 1 and both read-data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_mode | input | 1 | 1: serial side rotates over all lanes; 0: lane 0 only |
| tx_wr_word | input | 1 | Bus word write strobe, transmit side |
| tx_wdata_w | input | 32 | Word write data |
| tx_wr_byte | input | 1 | Bus byte write strobe, transmit side |
| tx_wdata_b | input | 8 | Byte write data |
| tx_ser_take | input | 1 | Serial side consumes the presented byte |
| tx_ser_valid | output | 1 | A transmit byte is presented |
| tx_ser_byte | output | 8 | Presented transmit byte |
| rx_ser_put | input | 1 | Serial side delivers a received byte |
| rx_ser_byte | input | 8 | Received byte |
| rx_ser_ready | output | 1 | Selected receive lane has room |
| rx_rd_word | input | 1 | Bus word read strobe, receive side |
| rx_rd_byte | input | 1 | Bus byte read strobe, receive side |
| rx_rdata_w | output | 32 | Registered word read data |
| rx_rdata_b | output | 8 | Registered byte read data |
| stat_clr_we | input | 1 | Apply the clear mask this cycle |
| stat_clr_mask | input | 13 | Status bits to clear |
| ien_we | input | 1 | Load the interrupt enable mask |
| ien_wdata | input | 13 | New interrupt enable mask |
| status | output | 13 | Latched status vector |
| ien | output | 13 | Current interrupt enable mask |
| irq | output | 1 | Interrupt request |

## Verification
A bus or serial access changes the lane counts at the edge that accepts it. The status vector shows the resulting flags, and any illegal-access event, one edge later. `rx_rdata_w` and `rx_rdata_b` are valid right after the accepting edge. The serial-side `tx_ser_valid`, `tx_ser_byte` and `rx_ser_ready` follow the counts with no further register. The bench therefore applies each access together with a clear of every status bit, drops both after one edge, and compares the whole status word and `irq` after the next edge. The serial outputs are read before each access is applied, and the bus read data is read after the accepting edge.

// File: rtl/qlf_pkg.sv
package qlf_pkg;
  localparam int STAT_W     = 13;
  // transmit flags
  localparam int B_TX_TRIG  = 0;
  localparam int B_TX_EMPTY = 1;
  localparam int B_TX_HALF  = 2;
  localparam int B_TX_FULL  = 3;
  // receive flags
  localparam int B_RX_TRIG  = 5;
  localparam int B_RX_WORD  = 6;
  localparam int B_RX_HALF  = 7;
  localparam int B_RX_FULL  = 8;
  localparam int B_RX_BYTE  = 11;
  // bus misuse event
  localparam int B_ILLEGAL  = 12;
  localparam logic [STAT_W-1:0] IEN_RESET = STAT_W'(1) << B_ILLEGAL;
endpackage

// File: rtl/qlf_lane.sv
// One byte-wide lane: small register-file FIFO with occupancy counter.
module qlf_lane #(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [7:0]    din,
  input  logic          pop,
  output logic [7:0]    dout,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          nempty
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout   = mem[rp];
  assign full   = (cnt == CW'(DEPTH));
  assign nempty = (cnt != '0);

  // R7: the enclosing store never pushes a full lane or pops an empty one
  a_r7_push_room: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  a_r7_pop_data:  assert property (@(posedge clk) disable iff (rst) pop |-> nempty);
  // R1: a lone push raises the occupancy by exactly one
  a_r1_count_up:  assert property (@(posedge clk) disable iff (rst)
                    (push && !pop) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/qlf_store.sv
// Four (LANES) byte lanes with word/byte bus access and a rotating serial port.
module qlf_store #(
  parameter  int LANES  = 4,
  parameter  int DEPTH  = 16,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int LVW    = $clog2(LANES * DEPTH + 1),
  localparam int LSW    = $clog2(LANES),
  localparam int WORD_W = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_mode,
  input  logic              push_word,
  input  logic [WORD_W-1:0] push_wdata,
  input  logic              push_byte,
  input  logic [7:0]        push_bdata,
  input  logic              push_ser,
  input  logic [7:0]        push_sdata,
  input  logic              pop_word,
  input  logic              pop_byte,
  input  logic              pop_ser,
  output logic              ser_has,
  output logic              ser_room,
  output logic [7:0]        ser_dout,
  output logic [WORD_W-1:0] rd_word_q,
  output logic [7:0]        rd_byte_q,
  output logic              err_q,
  output logic [LVW-1:0]    mode_lvl,
  output logic              mode_full,
  output logic              mode_half,
  output logic              mode_empty,
  output logic              all_ne,
  output logic              lane0_ne
);
  localparam int HALF_W = (LANES * DEPTH) / 2;
  localparam int HALF_B = DEPTH / 2;

  logic [LANES-1:0] full, nempty, l_push, l_pop;
  logic [7:0]       l_dout [LANES];
  logic [CW-1:0]    l_cnt  [LANES];
  logic [LSW-1:0]   ptr, sel;
  logic             any_full;
  logic             pw_push, pb_push, ps_push, pw_pop, pb_pop, ps_pop;
  logic [LVW-1:0]   sum_lvl;

  assign sel      = word_mode ? ptr : '0;
  assign any_full = |full;
  assign all_ne   = &nempty;
  assign lane0_ne = nempty[0];

  // accepted operations; a word access takes precedence over a byte access
  assign pw_push = push_word & ~any_full;
  assign pb_push = push_byte & ~push_word & ~full[0];
  assign ps_push = push_ser  & ~full[sel];
  assign pw_pop  = pop_word  & all_ne;
  assign pb_pop  = pop_byte  & ~pop_word & nempty[0];
  assign ps_pop  = pop_ser   & nempty[sel];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] din;
    assign l_push[g] = pw_push | (pb_push & (g == 0)) | (ps_push & (sel == LSW'(g)));
    assign l_pop[g]  = pw_pop  | (pb_pop  & (g == 0)) | (ps_pop  & (sel == LSW'(g)));
    assign din = push_word ? push_wdata[8*g +: 8] : (push_byte ? push_bdata : push_sdata);
    qlf_lane #(.DEPTH(DEPTH)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .push   (l_push[g]),
      .din    (din),
      .pop    (l_pop[g]),
      .dout   (l_dout[g]),
      .cnt    (l_cnt[g]),
      .full   (full[g]),
      .nempty (nempty[g])
    );
  end

  // serial lane pointer: rotates in word mode, parked on lane 0 otherwise
  always_ff @(posedge clk) begin
    if (rst || !word_mode) ptr <= '0;
    else if (ps_push || ps_pop) ptr <= (ptr == LSW'(LANES - 1)) ? '0 : ptr + 1'b1;
  end

  assign ser_has  = nempty[sel];
  assign ser_room = ~full[sel];
  assign ser_dout = l_dout[sel];

  always_comb begin
    sum_lvl = '0;
    for (int i = 0; i < LANES; i++) sum_lvl = sum_lvl + LVW'(l_cnt[i]);
  end

  assign mode_lvl   = word_mode ? sum_lvl  : LVW'(l_cnt[0]);
  assign mode_full  = word_mode ? any_full : full[0];
  assign mode_half  = mode_lvl >= (word_mode ? LVW'(HALF_W) : LVW'(HALF_B));
  assign mode_empty = (mode_lvl == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_word_q <= '0;
      rd_byte_q <= '0;
      err_q     <= 1'b0;
    end else begin
      if (pw_pop) begin
        for (int i = 0; i < LANES; i++) rd_word_q[8*i +: 8] <= l_dout[i];
      end
      if (pb_pop) rd_byte_q <= l_dout[0];
      err_q <= (push_word & any_full) | (push_byte & ~push_word & full[0]) |
               (pop_word & ~all_ne)   | (pop_byte & ~pop_word & ~nempty[0]);
    end
  end

  // R3: in word mode each serial transfer moves to the next lane
  a_r3_rotate: assert property (@(posedge clk) disable iff (rst)
    (word_mode && (ps_push || ps_pop)) |=>
      (!word_mode || ptr == (($past(ptr) == LSW'(LANES - 1)) ? '0 : $past(ptr) + 1'b1)));
endmodule

// File: rtl/qlf_status.sv
// Sticky status vector with write-one-to-clear and an enable mask.
module qlf_status #(
  parameter int          W       = 13,
  parameter logic [W-1:0] IEN_RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cond,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  input  logic         ien_we,
  input  logic [W-1:0] ien_wdata,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] ien_q,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      ien_q  <= IEN_RST;
    end else begin
      stat_q <= (stat_q | cond) & ~(clr_we ? clr_mask : '0);
      if (ien_we) ien_q <= ien_wdata;
    end
  end

  assign irq = |(stat_q & ien_q);

  // R6: a cleared bit reads zero right after the clear edge
  a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((stat_q & $past(clr_mask)) == '0));
  // R6: without a clear no set bit is lost
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  // R8: the enable mask changes only on an enable write
  a_r8_mask_hold: assert property (@(posedge clk) disable iff (rst)
    !ien_we |=> $stable(ien_q));
endmodule

// File: rtl/quad_lane_fifo.sv
module quad_lane_fifo
  import qlf_pkg::*;
#(
  parameter  int LANES      = 4,
  parameter  int LANE_DEPTH = 16,
  parameter  int TX_TRIG    = 8,
  parameter  int RX_TRIG    = 8,
  localparam int WORD_W     = 8 * LANES,
  localparam int LVW        = $clog2(LANES * LANE_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_mode,
  input  logic              tx_wr_word,
  input  logic [WORD_W-1:0] tx_wdata_w,
  input  logic              tx_wr_byte,
  input  logic [7:0]        tx_wdata_b,
  input  logic              tx_ser_take,
  output logic              tx_ser_valid,
  output logic [7:0]        tx_ser_byte,
  input  logic              rx_ser_put,
  input  logic [7:0]        rx_ser_byte,
  output logic              rx_ser_ready,
  input  logic              rx_rd_word,
  input  logic              rx_rd_byte,
  output logic [WORD_W-1:0] rx_rdata_w,
  output logic [7:0]        rx_rdata_b,
  input  logic              stat_clr_we,
  input  logic [STAT_W-1:0] stat_clr_mask,
  input  logic              ien_we,
  input  logic [STAT_W-1:0] ien_wdata,
  output logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] ien,
  output logic              irq
);
  logic [LVW-1:0]    tx_lvl, rx_lvl;
  logic              tx_full, tx_half, tx_empty, tx_err;
  logic              rx_full, rx_half, rx_word_av, rx_byte_av, rx_err;
  logic              tx_unused_room, tx_unused_ane, tx_unused_l0;
  logic [WORD_W-1:0] tx_unused_rdw;
  logic [7:0]        tx_unused_rdb;
  logic              rx_unused_has, rx_unused_empty;
  logic [7:0]        rx_unused_dout;
  logic [STAT_W-1:0] cond;

  qlf_store #(.LANES(LANES), .DEPTH(LANE_DEPTH)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .word_mode  (word_mode),
    .push_word  (tx_wr_word),
    .push_wdata (tx_wdata_w),
    .push_byte  (tx_wr_byte),
    .push_bdata (tx_wdata_b),
    .push_ser   (1'b0),
    .push_sdata (8'h00),
    .pop_word   (1'b0),
    .pop_byte   (1'b0),
    .pop_ser    (tx_ser_take),
    .ser_has    (tx_ser_valid),
    .ser_room   (tx_unused_room),
    .ser_dout   (tx_ser_byte),
    .rd_word_q  (tx_unused_rdw),
    .rd_byte_q  (tx_unused_rdb),
    .err_q      (tx_err),
    .mode_lvl   (tx_lvl),
    .mode_full  (tx_full),
    .mode_half  (tx_half),
    .mode_empty (tx_empty),
    .all_ne     (tx_unused_ane),
    .lane0_ne   (tx_unused_l0)
  );

  qlf_store #(.LANES(LANES), .DEPTH(LANE_DEPTH)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .word_mode  (word_mode),
    .push_word  (1'b0),
    .push_wdata ('0),
    .push_byte  (1'b0),
    .push_bdata (8'h00),
    .push_ser   (rx_ser_put),
    .push_sdata (rx_ser_byte),
    .pop_word   (rx_rd_word),
    .pop_byte   (rx_rd_byte),
    .pop_ser    (1'b0),
    .ser_has    (rx_unused_has),
    .ser_room   (rx_ser_ready),
    .ser_dout   (rx_unused_dout),
    .rd_word_q  (rx_rdata_w),
    .rd_byte_q  (rx_rdata_b),
    .err_q      (rx_err),
    .mode_lvl   (rx_lvl),
    .mode_full  (rx_full),
    .mode_half  (rx_half),
    .mode_empty (rx_unused_empty),
    .all_ne     (rx_word_av),
    .lane0_ne   (rx_byte_av)
  );

  always_comb begin
    cond             = '0;
    cond[B_TX_TRIG]  = (int'(tx_lvl) <= TX_TRIG);
    cond[B_TX_EMPTY] = tx_empty;
    cond[B_TX_HALF]  = tx_half;
    cond[B_TX_FULL]  = tx_full;
    cond[B_RX_TRIG]  = (int'(rx_lvl) >= RX_TRIG);
    cond[B_RX_WORD]  = rx_word_av;
    cond[B_RX_HALF]  = rx_half;
    cond[B_RX_FULL]  = rx_full;
    cond[B_RX_BYTE]  = rx_byte_av;
    cond[B_ILLEGAL]  = tx_err | rx_err;
  end

  qlf_status #(.W(STAT_W), .IEN_RST(IEN_RESET)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .cond      (cond),
    .clr_we    (stat_clr_we),
    .clr_mask  (stat_clr_mask),
    .ien_we    (ien_we),
    .ien_wdata (ien_wdata),
    .stat_q    (status),
    .ien_q     (ien),
    .irq       (irq)
  );
endmodule

// File: tb/quad_lane_fifo_tb_top.sv
`timescale 1ns/1ps
module quad_lane_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_mode = 1'b1;
  logic        tx_wr_word = 0, tx_wr_byte = 0, tx_ser_take = 0;
  logic [31:0] tx_wdata_w = '0;
  logic [7:0]  tx_wdata_b = '0;
  logic        tx_ser_valid;
  logic [7:0]  tx_ser_byte;
  logic        rx_ser_put = 0, rx_rd_word = 0, rx_rd_byte = 0;
  logic [7:0]  rx_ser_byte = '0;
  logic        rx_ser_ready;
  logic [31:0] rx_rdata_w;
  logic [7:0]  rx_rdata_b;
  logic        stat_clr_we = 0, ien_we = 0;
  logic [12:0] stat_clr_mask = '0, ien_wdata = '0;
  logic [12:0] status, ien;
  logic        irq;

  int checks = 0, fails = 0;
  int txc[4], rxc[4];
  int txp = 0, rxp = 0;
  bit exp_err = 0;

  always #2 clk = ~clk;

  quad_lane_fifo dut_i (
    .clk(clk), .rst(rst), .word_mode(word_mode),
    .tx_wr_word(tx_wr_word), .tx_wdata_w(tx_wdata_w), .tx_wr_byte(tx_wr_byte),
    .tx_wdata_b(tx_wdata_b), .tx_ser_take(tx_ser_take), .tx_ser_valid(tx_ser_valid),
    .tx_ser_byte(tx_ser_byte), .rx_ser_put(rx_ser_put), .rx_ser_byte(rx_ser_byte),
    .rx_ser_ready(rx_ser_ready), .rx_rd_word(rx_rd_word), .rx_rd_byte(rx_rd_byte),
    .rx_rdata_w(rx_rdata_w), .rx_rdata_b(rx_rdata_b), .stat_clr_we(stat_clr_we),
    .stat_clr_mask(stat_clr_mask), .ien_we(ien_we), .ien_wdata(ien_wdata),
    .status(status), .ien(ien), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [7:0] wbyte(input int i, input int l);
    return 8'(i * 37 + l * 11 + 5);
  endfunction
  function automatic logic [7:0] bval(input int i);
    return 8'(i * 13 + 7);
  endfunction
  function automatic logic [7:0] rbyte(input int j);
    return 8'(j * 29 + 3);
  endfunction

  function automatic logic [12:0] exp_stat(input bit err);
    int tl, rl, cap;
    logic [12:0] e;
    tl  = word_mode ? txc[0] + txc[1] + txc[2] + txc[3] : txc[0];
    rl  = word_mode ? rxc[0] + rxc[1] + rxc[2] + rxc[3] : rxc[0];
    cap = word_mode ? 64 : 16;
    e = '0;
    e[0]  = (tl <= 8);
    e[1]  = (tl == 0);
    e[2]  = (tl >= cap / 2);
    e[3]  = word_mode ? (txc[0] == 16 || txc[1] == 16 || txc[2] == 16 || txc[3] == 16)
                      : (txc[0] == 16);
    e[5]  = (rl >= 8);
    e[6]  = (rxc[0] > 0 && rxc[1] > 0 && rxc[2] > 0 && rxc[3] > 0);
    e[7]  = (rl >= cap / 2);
    e[8]  = word_mode ? (rxc[0] == 16 || rxc[1] == 16 || rxc[2] == 16 || rxc[3] == 16)
                      : (rxc[0] == 16);
    e[11] = (rxc[0] > 0);
    e[12] = err;
    return e;
  endfunction

  // strobes already driven by caller; clear all status in the same cycle
  task automatic run_op(input string tag);
    stat_clr_we = 1; stat_clr_mask = '1;
    step();
    stat_clr_we = 0; stat_clr_mask = '0;
    tx_wr_word = 0; tx_wr_byte = 0; tx_ser_take = 0;
    rx_ser_put = 0; rx_rd_word = 0; rx_rd_byte = 0;
    step();
    chk({tag, " status"}, 32'(status), 32'(exp_stat(exp_err)));
    chk("R8 irq follows enabled bit 12", 32'(irq), 32'(exp_err));
    exp_err = 0;
  endtask

  task automatic tx_word(input int i, input string tag);
    bit ok;
    ok = (txc[0] < 16 && txc[1] < 16 && txc[2] < 16 && txc[3] < 16);
    tx_wr_word = 1;
    tx_wdata_w = {wbyte(i, 3), wbyte(i, 2), wbyte(i, 1), wbyte(i, 0)};
    if (ok) for (int l = 0; l < 4; l++) txc[l]++;
    exp_err = !ok;
    run_op(tag);
  endtask

  task automatic tx_pop(input logic [7:0] exp_b, input string tag);
    int sel;
    bit has;
    sel = word_mode ? txp : 0;
    has = (txc[sel] > 0);
    chk("R3 tx serial valid", 32'(tx_ser_valid), 32'(has));
    if (has) chk({tag, " tx byte order"}, 32'(tx_ser_byte), 32'(exp_b));
    tx_ser_take = 1;
    if (has) begin
      txc[sel]--;
      if (word_mode) txp = (txp + 1) % 4;
    end
    run_op("R4 tx after take");
  endtask

  task automatic rx_put(input logic [7:0] b);
    int sel;
    bit room;
    sel  = word_mode ? rxp : 0;
    room = (rxc[sel] < 16);
    chk("R3 rx serial ready", 32'(rx_ser_ready), 32'(room));
    rx_ser_put = 1; rx_ser_byte = b;
    if (room) begin
      rxc[sel]++;
      if (word_mode) rxp = (rxp + 1) % 4;
    end
    run_op("R5 rx after put");
  endtask

  task automatic rx_word(input logic [31:0] exp_w, input string tag);
    bit ok;
    ok = (rxc[0] > 0 && rxc[1] > 0 && rxc[2] > 0 && rxc[3] > 0);
    rx_rd_word = 1;
    if (ok) for (int l = 0; l < 4; l++) rxc[l]--;
    exp_err = !ok;
    stat_clr_we = 1; stat_clr_mask = '1;
    step();
    if (ok) chk({tag, " word data"}, rx_rdata_w, exp_w);
    stat_clr_we = 0; stat_clr_mask = '0; rx_rd_word = 0;
    step();
    chk("R7 rx word read status", 32'(status), 32'(exp_stat(exp_err)));
    exp_err = 0;
  endtask

  task automatic rx_byte(input logic [7:0] exp_b, input string tag);
    bit ok;
    ok = (rxc[0] > 0);
    rx_rd_byte = 1;
    if (ok) rxc[0]--;
    exp_err = !ok;
    stat_clr_we = 1; stat_clr_mask = '1;
    step();
    if (ok) chk({tag, " byte data"}, 32'(rx_rdata_b), 32'(exp_b));
    stat_clr_we = 0; stat_clr_mask = '0; rx_rd_byte = 0;
    step();
    chk("R7 rx byte read status", 32'(status), 32'(exp_stat(exp_err)));
    exp_err = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int l = 0; l < 4; l++) begin txc[l] = 0; rxc[l] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R10 reset state
    chk("R10 status after reset", 32'(status), 32'h0);
    chk("R10 enable after reset", 32'(ien), 32'h1000);
    chk("R10 irq after reset", 32'(irq), 32'h0);
    chk("R10 tx valid after reset", 32'(tx_ser_valid), 32'h0);
    chk("R10 rx ready after reset", 32'(rx_ser_ready), 32'h1);
    chk("R10 rx word data after reset", rx_rdata_w, 32'h0);
    chk("R10 rx byte data after reset", 32'(rx_rdata_b), 32'h0);
    step();
    chk("R4 first flags", 32'(status), 32'h0003);

    // transmit, word mode: fill past 64 bytes, drain past empty
    word_mode = 1;
    for (int i = 0; i < 17; i++) tx_word(i, (i == 16) ? "R7 tx word into full" : "R1 tx word");
    for (int j = 0; j < 65; j++) tx_pop(wbyte(j / 4, j % 4), "R1 R3 word mode");

    // transmit, byte mode: 16-byte depth on lane 0
    word_mode = 0; txp = 0; rxp = 0;
    for (int i = 0; i < 17; i++) begin
      bit ok;
      ok = (txc[0] < 16);
      tx_wr_byte = 1; tx_wdata_b = bval(i);
      if (ok) txc[0]++;
      exp_err = !ok;
      run_op((i == 16) ? "R2 R7 tx byte into full" : "R2 tx byte");
    end
    for (int j = 0; j < 17; j++) tx_pop(bval(j), "R2 byte mode");

    // receive, word mode: 65 puts (last dropped), 17 word reads (last refused)
    word_mode = 1;
    for (int j = 0; j < 65; j++) rx_put(rbyte(j));
    for (int k = 0; k < 17; k++)
      rx_word({rbyte(4*k+3), rbyte(4*k+2), rbyte(4*k+1), rbyte(4*k)}, "R1 rx");

    // receive, byte mode
    word_mode = 0; txp = 0; rxp = 0;
    for (int j = 0; j < 17; j++) rx_put(rbyte(100 + j));
    for (int j = 0; j < 17; j++) rx_byte(rbyte(100 + j), "R2 rx");

    // partial word availability in word mode (R5, R7)
    word_mode = 1;
    for (int n = 0; n < 3; n++) rx_put(8'(n * 7 + 8'h40));
    rx_word(32'h0, "R5 no whole word");
    rx_byte(8'h40, "R5 byte from lane 0");
    rx_put(8'(3 * 7 + 8'h40));
    rx_word(32'h0, "R5 lane 0 empty");
    for (int n = 4; n < 8; n++) rx_put(8'(n * 7 + 8'h40));
    rx_word({8'(3*7+8'h40), 8'(2*7+8'h40), 8'(1*7+8'h40), 8'(4*7+8'h40)}, "R5 mixed lanes");

    // R9: word and byte write together, word wins
    tx_wr_word = 1; tx_wdata_w = {wbyte(100,3), wbyte(100,2), wbyte(100,1), wbyte(100,0)};
    tx_wr_byte = 1; tx_wdata_b = 8'hEE;
    for (int l = 0; l < 4; l++) txc[l]++;
    run_op("R9 word beats byte");
    for (int l = 0; l < 4; l++) tx_pop(wbyte(100, l), "R9 only word stored");
    tx_pop(8'h00, "R9 nothing extra");

    // R6 sticky and clear-then-reset behaviour (tx empty)
    stat_clr_we = 1; stat_clr_mask = 13'h0002;
    step();
    stat_clr_we = 0; stat_clr_mask = '0;
    chk("R6 cleared bit reads 0", 32'(status[1]), 32'h0);
    step();
    chk("R6 still-true bit set again", 32'(status[1]), 32'h1);
    tx_wr_word = 1; tx_wdata_w = 32'h11223344;
    step();
    tx_wr_word = 0;
    step();
    chk("R6 empty stays latched", 32'(status[1]), 32'h1);
    for (int l = 0; l < 4; l++) txc[l]++;
    run_op("R6 after clear");
    tx_pop(8'h44, "R6 drain");
    tx_pop(8'h33, "R6 drain");
    tx_pop(8'h22, "R6 drain");
    tx_pop(8'h11, "R6 drain");

    // R8 enable mask
    ien_we = 1; ien_wdata = 13'h0002;
    step();
    ien_we = 0;
    chk("R8 enable written", 32'(ien), 32'h0002);
    chk("R8 irq from tx empty", 32'(irq), 32'h1);
    ien_we = 1; ien_wdata = 13'h0000;
    step();
    ien_we = 0;
    chk("R8 irq masked", 32'(irq), 32'h0);
    ien_we = 1; ien_wdata = 13'h1000;
    step();
    ien_we = 0;
    chk("R5 reserved bits zero", 32'(status & 13'h0610), 32'h0);

    finish_run();
  end
endmodule